// File: doc/BRIEF.md
# Byte-Count I2C Master Sequencer

This block drives a master transfer on an I2C bus one byte at a time. It talks to an abstract bus agent that carries out four operations: start with an address and a direction, send a byte and report its acknowledge, receive a byte, and stop. Each operation is requested with a level signal and completed by a one-cycle done pulse from the agent. The block takes a 16-bit control word with self-clearing start and stop bits and a programmed transfer count. It moves bytes between the agent and a small byte buffer that the host fills or drains. It raises four status flags: receive-ready, transmit-ready, access-ready and no-acknowledge.

The block has two flows. In count mode, every byte moved lowers a working count. When that count reaches zero, the block either issues a stop or, when stop was not requested, reports access-ready and leaves the bus held. In repeat mode the count is ignored. A transmit drains the buffer and a receive fills it to the top, and a stop goes out at the next evaluation once the stop bit is set. The sequencer works only while it holds the bus. After each run it waits, and it runs again when the host pushes or pops a buffer byte.

Top module: `i2c_byte_seq`

## Requirements
- R1: A control write keeps only the bits under 16'hCF87. The bits are: bit 15 enable, bit 14 byte order (stored only), bit 10 master, bit 9 transmit, bit 8 ten-bit addressing, bit 2 repeat, bit 1 stop, bit 0 start. `ctrl_rd` returns the kept bits, and all registers read zero after reset.
- R2: A write with start set issues a bus start only when enable and master are both 1 and ten-bit addressing is 0. A write that fails this test requests nothing on the bus and keeps its start bit as written.
- R3: An accepted start requests `bus_op`=0 with `bus_addr`=`slv_addr` and `bus_rd` equal to the inverse of the transmit bit. The start bit reads 0 afterwards, and the buffer is emptied.
- R4: A start that is not acknowledged sets no-acknowledge, clears the stop bit, leaves the bus not held and requests nothing more.
- R5: An acknowledged start marks the bus held (`bus_busy`=1) and loads the working count from the programmed count.
- R6: In count mode, each byte sent (`bus_op`=1) or received (`bus_op`=2) lowers the working count by one. `cnt_rd` shows the working count. Sent bytes leave in buffer order, and received bytes are popped in arrival order.
- R7: When the working count is zero and the stop bit is set, a stop (`bus_op`=3) is issued. After it, the stop bit reads 0, the working count is reloaded from the programmed count, and the bus is no longer held.
- R8: In a count-mode transmit, a zero working count sets access-ready and clears the master bit. In a count-mode receive, a zero count with stop clear does the same, and the bus stays held.
- R9: In count mode, transmit-ready is set when the buffer is empty and count remains, and it is cleared when the count is zero or a send is not acknowledged. Receive-ready follows a non-empty buffer at the end of a receive evaluation.
- R10: A send that is not acknowledged sets no-acknowledge and clears the stop bit. No stop follows until the next evaluation.
- R11: In repeat mode the count is neither checked nor changed. A transmit sends every buffered byte and sets transmit-ready. A receive fills the buffer to its depth and sets receive-ready.
- R12: In repeat mode with the stop bit set, the next evaluation issues a stop, clears the stop bit and empties the buffer without sending.
- R13: The sequencer requests send, receive or stop only while the bus is held. Buffer pushes or pops while the bus is not held cause no bus request.
- R14: Pulsing `clr_ardy` or `clr_nack` clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 16 | Control write value |
| ctrl_rd | output | 16 | Control register contents |
| cnt_we | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CNT_W | Programmed count value |
| cnt_rd | output | CNT_W | Working count |
| slv_addr | input | ADDR_W | Target address for starts |
| host_push | input | 1 | Host pushes a transmit byte |
| host_byte | input | 8 | Byte pushed by the host |
| host_pop | input | 1 | Host pops the buffer head |
| rx_byte | output | 8 | Buffer head byte |
| buf_level | output | $clog2(DEPTH+1) | Bytes held in the buffer |
| clr_ardy | input | 1 | Clear access-ready |
| clr_nack | input | 1 | Clear no-acknowledge |
| st_nack | output | 1 | No-acknowledge flag |
| st_ardy | output | 1 | Access-ready flag |
| st_rrdy | output | 1 | Receive-ready flag |
| st_xrdy | output | 1 | Transmit-ready flag |
| bus_busy | output | 1 | Bus held by this master |
| bus_req | output | 1 | Agent request, held until done |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | ADDR_W | Address for start |
| bus_rd | output | 1 | Start direction, 1 = read |
| bus_wbyte | output | 8 | Byte to send |
| bus_done | input | 1 | Agent completion pulse |
| bus_ack | input | 1 | Acknowledge for start or send |
| bus_rbyte | input | 8 | Byte received by the agent |

## Verification
The bench builds the block with DEPTH=4, CNT_W=16 and ADDR_W=10. A four-byte buffer lets a sweep of receive counts from one to six cover two cases: transfers that finish inside one buffer fill, and transfers that must wait for host pops before refilling. Transmit counts from one to four are swept both with and without an automatic stop. Each run's expected working count, byte order and final flag state follow directly from the count and the step index.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    localparam int CB_EN  = 15;
    localparam int CB_BE  = 14;
    localparam int CB_MST = 10;
    localparam int CB_TRX = 9;
    localparam int CB_XA  = 8;
    localparam int CB_RPT = 2;
    localparam int CB_STP = 1;
    localparam int CB_STT = 0;
    localparam logic [15:0] CTRL_KEEP = 16'hCF87;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_EVAL,
        S_SEND,
        S_RECV,
        S_STOP,
        S_HOLD
    } seq_st_e;
endpackage

// File: rtl/seq_byte_buf.sv
module seq_byte_buf #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } buf_t;

    buf_t b_q, b_d;
    logic [DW-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_rd = rd_en && (b_q.lvl != '0);
        do_wr = wr_en && ((b_q.lvl != LW'(DEPTH)) || do_rd);
        b_d   = b_q;
        if (do_wr) b_d.wp = bump(b_q.wp);
        if (do_rd) b_d.rp = bump(b_q.rp);
        if (do_wr && !do_rd) b_d.lvl = b_q.lvl + LW'(1);
        if (do_rd && !do_wr) b_d.lvl = b_q.lvl - LW'(1);
        if (flush) b_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[b_q.wp] <= wr_data;
    end

    assign rd_data = mem[b_q.rp];
    assign level   = b_q.lvl;

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.lvl <= LW'(DEPTH));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    output logic [15:0]       ctrl_rd,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rd,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic              clr_ardy,
    input  logic              clr_nack,
    input  logic              host_touch,
    input  logic [LW-1:0]     q_level,
    input  logic [7:0]        q_head,
    output logic              q_pop,
    output logic              q_push,
    output logic [7:0]        q_wdata,
    output logic              q_flush,
    output logic              st_nack,
    output logic              st_ardy,
    output logic              st_rrdy,
    output logic              st_xrdy,
    output logic              bus_busy,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic [7:0]        bus_wbyte,
    input  logic              bus_done,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rbyte
);
    typedef struct packed {
        seq_st_e           st;
        logic [15:0]       ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cur;
        logic              busy;
        logic              nack;
        logic              ardy;
        logic              rrdy;
        logic              xrdy;
        logic              wake;
        logic [7:0]        wbyte;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } seq_t;

    seq_t r_q, r_d;

    logic can_write, start_ok, lvl_empty, lvl_full;
    logic rpt, trx, stp, cur_zero;

    always_comb begin
        can_write = (r_q.st == S_IDLE) || (r_q.st == S_HOLD);
        start_ok  = ctrl_wdata[CB_EN] && ctrl_wdata[CB_MST] && !ctrl_wdata[CB_XA];
        lvl_empty = (q_level == '0);
        lvl_full  = (q_level == LW'(DEPTH));
        rpt       = r_q.ctrl[CB_RPT];
        trx       = r_q.ctrl[CB_TRX];
        stp       = r_q.ctrl[CB_STP];
        cur_zero  = (r_q.cur == '0);
    end

    always_comb begin
        r_d     = r_q;
        q_pop   = 1'b0;
        q_push  = 1'b0;
        q_flush = 1'b0;
        q_wdata = bus_rbyte;

        if (cnt_we)   r_d.cnt  = cnt_wdata;
        if (clr_ardy) r_d.ardy = 1'b0;
        if (clr_nack) r_d.nack = 1'b0;
        r_d.wake = r_q.wake | host_touch;

        unique case (r_q.st)
            S_IDLE: ;
            S_HOLD: begin
                if (r_q.wake || host_touch) r_d.st = S_EVAL;
            end
            S_START: begin
                if (bus_done) begin
                    if (!bus_ack) begin
                        r_d.nack         = 1'b1;
                        r_d.ctrl[CB_STP] = 1'b0;
                        r_d.busy         = 1'b0;
                        r_d.st           = S_IDLE;
                    end else begin
                        r_d.busy = 1'b1;
                        r_d.cur  = r_q.cnt;
                        r_d.st   = S_EVAL;
                    end
                end
            end
            S_EVAL: begin
                if (rpt) begin
                    if (stp) begin
                        r_d.st = S_STOP;
                    end else if (trx) begin
                        if (!lvl_empty) begin
                            q_pop     = 1'b1;
                            r_d.wbyte = q_head;
                            r_d.st    = S_SEND;
                        end else begin
                            r_d.xrdy = 1'b1;
                            r_d.st   = S_HOLD;
                        end
                    end else begin
                        if (!lvl_full) begin
                            r_d.st = S_RECV;
                        end else begin
                            r_d.rrdy = 1'b1;
                            r_d.st   = S_HOLD;
                        end
                    end
                end else if (trx) begin
                    if (!cur_zero && !lvl_empty) begin
                        q_pop     = 1'b1;
                        r_d.wbyte = q_head;
                        r_d.st    = S_SEND;
                    end else begin
                        r_d.xrdy = !cur_zero;
                        r_d.st   = S_HOLD;
                        if (cur_zero) begin
                            r_d.ardy         = 1'b1;
                            r_d.ctrl[CB_MST] = 1'b0;
                            if (stp) r_d.st = S_STOP;
                        end
                    end
                end else begin
                    if (!cur_zero && !lvl_full) begin
                        r_d.st = S_RECV;
                    end else begin
                        r_d.rrdy = !lvl_empty;
                        r_d.st   = S_HOLD;
                        if (cur_zero) begin
                            if (stp) begin
                                r_d.st = S_STOP;
                            end else begin
                                r_d.ardy         = 1'b1;
                                r_d.ctrl[CB_MST] = 1'b0;
                            end
                        end
                    end
                end
            end
            S_SEND: begin
                if (bus_done) begin
                    if (!rpt) r_d.cur = r_q.cur - CNT_W'(1);
                    if (bus_ack) begin
                        r_d.st = S_EVAL;
                    end else begin
                        r_d.nack         = 1'b1;
                        r_d.ctrl[CB_STP] = 1'b0;
                        if (!rpt) r_d.xrdy = 1'b0;
                        r_d.st           = S_HOLD;
                    end
                end
            end
            S_RECV: begin
                if (bus_done) begin
                    q_push = 1'b1;
                    if (!rpt) r_d.cur = r_q.cur - CNT_W'(1);
                    r_d.st = S_EVAL;
                end
            end
            S_STOP: begin
                if (bus_done) begin
                    r_d.ctrl[CB_STP] = 1'b0;
                    r_d.cur          = r_q.cnt;
                    r_d.busy         = 1'b0;
                    if (trx) q_flush = 1'b1;
                    r_d.st           = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (ctrl_we && can_write) begin
            r_d.ctrl = ctrl_wdata & CTRL_KEEP;
            if (start_ok && ctrl_wdata[CB_STT]) begin
                r_d.ctrl[CB_STT] = 1'b0;
                q_flush          = 1'b1;
                r_d.addr         = slv_addr;
                r_d.rd           = !ctrl_wdata[CB_TRX];
                r_d.st           = S_START;
            end
        end

        if ((r_q.st == S_EVAL) || (r_d.st == S_EVAL)) r_d.wake = host_touch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req = 1'b0;
        bus_op  = OP_START;
        unique case (r_q.st)
            S_START: begin bus_req = 1'b1; bus_op = OP_START; end
            S_SEND:  begin bus_req = 1'b1; bus_op = OP_SEND;  end
            S_RECV:  begin bus_req = 1'b1; bus_op = OP_RECV;  end
            S_STOP:  begin bus_req = 1'b1; bus_op = OP_STOP;  end
            default: ;
        endcase
    end

    assign ctrl_rd   = r_q.ctrl;
    assign cnt_rd    = r_q.cur;
    assign st_nack   = r_q.nack;
    assign st_ardy   = r_q.ardy;
    assign st_rrdy   = r_q.rrdy;
    assign st_xrdy   = r_q.xrdy;
    assign bus_busy  = r_q.busy;
    assign bus_addr  = r_q.addr;
    assign bus_rd    = r_q.rd;
    assign bus_wbyte = r_q.wbyte;

    a_r2_reject_start: assert property (@(posedge clk) disable iff (!rst_n)
        (can_write && ctrl_we && !start_ok) |=> (r_q.st != S_START));
    a_r4_start_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_START && bus_done && !bus_ack) |=> (st_nack && !bus_busy && !ctrl_rd[CB_STP]));
    a_r5_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_START && bus_done && bus_ack) |=> (bus_busy && cnt_rd == $past(r_q.cnt)));
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SEND && bus_done && !rpt) |=> (cnt_rd == $past(cnt_rd) - CNT_W'(1)));
    a_r7_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_STOP && bus_done) |=> (!bus_busy && !ctrl_rd[CB_STP] && !bus_req));
    a_r11_rpt_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RECV && bus_done && rpt) |=> $stable(cnt_rd));
    a_r13_held_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op != OP_START) |-> bus_busy);
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    output logic [15:0]       ctrl_rd,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rd,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic              host_push,
    input  logic [7:0]        host_byte,
    input  logic              host_pop,
    output logic [7:0]        rx_byte,
    output logic [LW-1:0]     buf_level,
    input  logic              clr_ardy,
    input  logic              clr_nack,
    output logic              st_nack,
    output logic              st_ardy,
    output logic              st_rrdy,
    output logic              st_xrdy,
    output logic              bus_busy,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic [7:0]        bus_wbyte,
    input  logic              bus_done,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rbyte
);
    logic       q_pop, q_push, q_flush, host_touch;
    logic [7:0] q_wdata, q_head;
    logic [LW-1:0] q_level;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;

    always_comb begin
        wr_en      = q_push | host_push;
        wr_data    = q_push ? q_wdata : host_byte;
        rd_en      = q_pop | host_pop;
        host_touch = (host_push && !q_push && (q_level != LW'(DEPTH)))
                   | (host_pop && !q_pop && (q_level != '0));
    end

    seq_byte_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (q_flush),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (q_head),
        .level   (q_level)
    );

    seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rd    (ctrl_rd),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .cnt_rd     (cnt_rd),
        .slv_addr   (slv_addr),
        .clr_ardy   (clr_ardy),
        .clr_nack   (clr_nack),
        .host_touch (host_touch),
        .q_level    (q_level),
        .q_head     (q_head),
        .q_pop      (q_pop),
        .q_push     (q_push),
        .q_wdata    (q_wdata),
        .q_flush    (q_flush),
        .st_nack    (st_nack),
        .st_ardy    (st_ardy),
        .st_rrdy    (st_rrdy),
        .st_xrdy    (st_xrdy),
        .bus_busy   (bus_busy),
        .bus_req    (bus_req),
        .bus_op     (bus_op),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wbyte  (bus_wbyte),
        .bus_done   (bus_done),
        .bus_ack    (bus_ack),
        .bus_rbyte  (bus_rbyte)
    );

    assign rx_byte   = q_head;
    assign buf_level = q_level;
endmodule

// File: tb/tb_i2c_byte_seq.sv
module tb_i2c_byte_seq;
    localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200, XA = 16'h0100;
    localparam logic [15:0] RPT = 16'h0004, STP = 16'h0002, STT = 16'h0001;
    localparam logic [9:0]  SADDR = 10'h05A;

    logic clk = 0, rst_n = 0;
    logic ctrl_we = 0, cnt_we = 0, host_push = 0, host_pop = 0, clr_ardy = 0, clr_nack = 0;
    logic [15:0] ctrl_wdata = 0, ctrl_rd, cnt_wdata = 0, cnt_rd;
    logic [7:0] host_byte = 0, rx_byte, bus_wbyte, bus_rbyte;
    logic [2:0] buf_level;
    logic st_nack, st_ardy, st_rrdy, st_xrdy, bus_busy, bus_req, bus_rd, bus_done, bus_ack;
    logic [1:0] bus_op;
    logic [9:0] bus_addr;

    always #2 clk = ~clk;

    i2c_byte_seq #(.DEPTH(4), .CNT_W(16), .ADDR_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rd(cnt_rd), .slv_addr(SADDR),
        .host_push(host_push), .host_byte(host_byte), .host_pop(host_pop), .rx_byte(rx_byte),
        .buf_level(buf_level), .clr_ardy(clr_ardy), .clr_nack(clr_nack), .st_nack(st_nack),
        .st_ardy(st_ardy), .st_rrdy(st_rrdy), .st_xrdy(st_xrdy), .bus_busy(bus_busy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wbyte(bus_wbyte), .bus_done(bus_done), .bus_ack(bus_ack), .bus_rbyte(bus_rbyte));

    // bus agent model: answers each request after a short delay and logs it
    logic start_nack = 0;
    int   nack_idx = -1;
    int   wcnt, send_idx, recv_idx, n_ops;
    logic [1:0] log_op   [64];
    logic [9:0] log_addr [64];
    logic       log_rd   [64];
    logic [7:0] log_byte [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_done <= 0; bus_ack <= 0; bus_rbyte <= 0;
            wcnt <= 0; send_idx <= 0; recv_idx <= 0; n_ops <= 0;
        end else begin
            bus_done <= 0;
            if (bus_req && !bus_done) begin
                if (wcnt == 2) begin
                    wcnt <= 0;
                    bus_done <= 1;
                    log_op[n_ops]   <= bus_op;
                    log_addr[n_ops] <= bus_addr;
                    log_rd[n_ops]   <= bus_rd;
                    log_byte[n_ops] <= bus_wbyte;
                    n_ops <= n_ops + 1;
                    case (bus_op)
                        2'd0: bus_ack <= !start_nack;
                        2'd1: begin bus_ack <= (send_idx != nack_idx); send_idx <= send_idx + 1; end
                        2'd2: begin bus_rbyte <= 8'(8'hA0 + recv_idx); recv_idx <= recv_idx + 1; end
                        default: bus_ack <= 1;
                    endcase
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask
    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 0;
    endtask
    task automatic wr_cnt(logic [15:0] v);
        @(negedge clk); cnt_we = 1; cnt_wdata = v;
        @(negedge clk); cnt_we = 0;
    endtask
    task automatic push(logic [7:0] b);
        @(negedge clk); host_push = 1; host_byte = b;
        @(negedge clk); host_push = 0;
    endtask
    task automatic pop(output logic [7:0] b);
        @(negedge clk); b = rx_byte; host_pop = 1;
        @(negedge clk); host_pop = 0;
    endtask
    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] got;
        do_reset();
        @(negedge clk);
        // reset state (R1)
        chk("R1 reset ctrl", ctrl_rd, 0);
        chk("R1 reset cnt", cnt_rd, 0);
        chk("R1 reset req", bus_req, 0);
        chk("R1 reset flags", {st_nack, st_ardy, st_rrdy, st_xrdy, bus_busy}, 0);
        chk("R1 reset level", buf_level, 0);

        // count-mode transmit sweep, with and without automatic stop
        for (int s = 0; s < 2; s++) begin
            for (int n = 1; n <= 4; n++) begin
                do_reset();
                wr_cnt(16'(n));
                wr_ctrl(EN | MST | TRX | STT | (s != 0 ? STP : 16'h0));
                settle();
                chk("R3 start op", log_op[0], 0);
                chk("R3 start addr", log_addr[0], SADDR);
                chk("R3 start dir write", log_rd[0], 0);
                chk("R3 start bit clears", ctrl_rd[0], 0);
                chk("R5 held", bus_busy, 1);
                chk("R5 count loaded", cnt_rd, n);
                chk("R9 xrdy with count left", st_xrdy, 1);
                for (int i = 0; i < n; i++) begin
                    push(8'(16 * n + i));
                    settle();
                    if (i < n - 1) chk("R6 working count", cnt_rd, n - 1 - i);
                end
                for (int i = 0; i < n; i++) begin
                    chk("R6 send op", log_op[1 + i], 1);
                    chk("R6 send byte order", log_byte[1 + i], 16 * n + i);
                end
                chk("R8 ardy at zero", st_ardy, 1);
                chk("R8 master cleared", ctrl_rd[10], 0);
                chk("R9 xrdy clear at zero", st_xrdy, 0);
                if (s != 0) begin
                    chk("R7 op count", n_ops, n + 2);
                    chk("R7 stop op", log_op[n + 1], 3);
                    chk("R7 released", bus_busy, 0);
                    chk("R7 stop bit clears", ctrl_rd[1], 0);
                    chk("R7 count reloaded", cnt_rd, n);
                end else begin
                    chk("R8 no stop", n_ops, n + 1);
                    chk("R8 still held", bus_busy, 1);
                    chk("R8 count zero", cnt_rd, 0);
                end
            end
        end

        // count-mode receive sweep with stop, crossing the buffer depth
        for (int n = 1; n <= 6; n++) begin
            do_reset();
            wr_cnt(16'(n));
            wr_ctrl(EN | MST | STP | STT);
            settle();
            chk("R3 start dir read", log_rd[0], 1);
            chk("R9 rrdy", st_rrdy, 1);
            chk("R6 level", buf_level, (n > 4) ? 4 : n);
            chk("R6 rx working count", cnt_rd, (n > 4) ? n - 4 : n);
            for (int i = 0; i < n; i++) begin
                chk("R6 byte present", (buf_level != 0), 1);
                pop(got);
                chk("R6 rx byte order", got, 8'hA0 + i);
                settle();
            end
            chk("R7 rx op count", n_ops, n + 2);
            chk("R7 rx stop op", log_op[n + 1], 3);
            chk("R7 rx released", bus_busy, 0);
            chk("R13 no request after release", bus_req, 0);
        end

        // send not acknowledged
        do_reset();
        nack_idx = 1;
        wr_cnt(16'd3);
        wr_ctrl(EN | MST | TRX | STP | STT);
        settle();
        push(8'h31); settle();
        push(8'h32); settle();
        chk("R10 nack set", st_nack, 1);
        chk("R10 stop cleared", ctrl_rd[1], 0);
        chk("R10 count after nack", cnt_rd, 1);
        chk("R9 xrdy cleared by nack", st_xrdy, 0);
        chk("R10 no stop", n_ops, 3);
        push(8'h33); settle();
        chk("R10 resumed send", n_ops, 4);
        chk("R10 last op send", log_op[3], 1);
        chk("R8 ardy after resume", st_ardy, 1);
        chk("R10 still held", bus_busy, 1);
        @(negedge clk); clr_nack = 1; @(negedge clk); clr_nack = 0;
        chk("R14 nack cleared", st_nack, 0);
        @(negedge clk); clr_ardy = 1; @(negedge clk); clr_ardy = 0;
        chk("R14 ardy cleared", st_ardy, 0);
        nack_idx = -1;

        // start not acknowledged
        do_reset();
        start_nack = 1;
        wr_ctrl(EN | MST | TRX | STP | STT);
        settle();
        chk("R4 nack", st_nack, 1);
        chk("R4 ctrl after nack", ctrl_rd, EN | MST | TRX);
        chk("R4 not held", bus_busy, 0);
        chk("R4 one op", n_ops, 1);
        push(8'h55); settle();
        chk("R13 push while not held", n_ops, 1);
        start_nack = 0;

        // rejected starts and masking
        do_reset();
        wr_ctrl(EN | STT); settle();
        chk("R2 no master no start", n_ops, 0);
        chk("R2 start bit kept", ctrl_rd, EN | STT);
        wr_ctrl(EN | MST | XA | STT); settle();
        chk("R2 ten-bit no start", n_ops, 0);
        chk("R2 ten-bit ctrl", ctrl_rd, EN | MST | XA | STT);
        wr_ctrl(16'h7FFF); settle();
        chk("R1 masked readback", ctrl_rd, 16'h4F87);
        chk("R2 disabled no start", n_ops, 0);

        // repeat-mode transmit, then stop
        do_reset();
        wr_cnt(16'd2);
        wr_ctrl(EN | MST | TRX | RPT | STT);
        settle();
        chk("R11 xrdy idle", st_xrdy, 1);
        for (int i = 0; i < 3; i++) begin
            push(8'(8'h60 + i)); settle();
        end
        chk("R11 all sent", n_ops, 4);
        for (int i = 0; i < 3; i++) chk("R11 rpt byte", log_byte[1 + i], 8'h60 + i);
        chk("R11 count kept", cnt_rd, 2);
        chk("R11 xrdy after drain", st_xrdy, 1);
        wr_ctrl(EN | MST | TRX | RPT | STP);
        push(8'h77); settle();
        chk("R12 stop op", n_ops, 5);
        chk("R12 stop code", log_op[4], 3);
        chk("R12 released", bus_busy, 0);
        chk("R12 buffer emptied", buf_level, 0);
        chk("R12 stop bit clears", ctrl_rd[1], 0);

        // repeat-mode receive fills to depth
        do_reset();
        wr_cnt(16'd1);
        wr_ctrl(EN | MST | RPT | STT);
        settle();
        chk("R11 rx full", buf_level, 4);
        chk("R11 rx ops", n_ops, 5);
        chk("R11 rrdy", st_rrdy, 1);
        chk("R11 rx count kept", cnt_rd, 1);
        pop(got); settle();
        chk("R11 rx first byte", got, 8'hA0);
        chk("R11 refill", buf_level, 4);
        chk("R11 refill op", n_ops, 6);

        summary();
    end
endmodule